// File: doc/BRIEF.md
# Thermostat Trip Monitor with Fault-Count Filter

This block drives a thermostat alarm line from a stream of temperature conversions. Each time a conversion finishes, a one-cycle `conv_done` pulse arrives with a 16-bit two's complement result. The block compares that result against an upper and a lower trip point. A short run counter requires a chosen number of back-to-back qualifying conversions before the alarm fires, so a single noisy sample cannot trip it.

Two behaviours are selectable. In hysteresis mode the alarm follows the temperature: it rises after a run above the upper trip and falls on the first conversion below the lower trip. In latched-event mode an event holds the alarm until software reads any register or the sensor is put to sleep. The next event then waits for the opposite limit, so events alternate between overheating and recovery. The comparison precision follows the selected resolution, and a polarity input picks the active level of the output pin.

Top module: `thermo_trip_monitor`

## Requirements
- R1: `run_sel` codes 00, 01, 10 and 11 need 1, 2, 4 and 6 consecutive qualifying conversions before the alarm asserts; the run counter never exceeds 6.
- R2: `res_sel` codes 00, 01, 10 and 11 keep the top 9, 10, 11 and 12 bits of the sample and of both trip points for comparison, and ignore the lower bits (bits 3..0 are always ignored).
- R3: "Above" means masked sample > masked `trip_hi`, and "below" means masked sample < masked `trip_lo`, both as strict signed comparisons; equality does not qualify.
- R4: With `irq_mode`=0, the alarm asserts after the required run of conversions above, and deasserts on the first single conversion below. A conversion that fails the armed condition restarts the run at zero.
- R5: With `irq_mode`=1, the alarm asserts after the required run of conversions above. Further conversions then leave it asserted until a cycle with `rd_strobe`=1 clears it.
- R6: In `irq_mode`=1, each assertion flips the armed condition. After a clear, the next assertion needs a run of conversions below, and the one after that needs a run above.
- R7: A 0-to-1 change of `shutdown` clears an asserted alarm when `irq_mode`=1, and has no effect when `irq_mode`=0.
- R8: `alarm_o` is low when the alarm is active and `pol`=0, and high when active and `pol`=1. The inactive level is the opposite. The output updates at the same edge as the alarm state.
- R9: `rst` or `soft_rst` deasserts the alarm, zeroes the run count and arms the upper condition; `alarm_o` is 1 during reset.
- R10: The alarm state changes only at a `conv_done` cycle, except for the clears of R5 and R7. If a clear and a conversion arrive together while the alarm is active, the alarm clears and the conversion is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous command reset, same effect as `rst` |
| conv_done | input | 1 | One-cycle pulse: `sample` holds a new result |
| sample | input | 16 | Conversion result, two's complement |
| trip_hi | input | 16 | Upper trip point, same format |
| trip_lo | input | 16 | Lower trip point, same format |
| res_sel | input | 2 | Resolution select (9..12 bits) |
| run_sel | input | 2 | Consecutive-count select (1, 2, 4, 6) |
| pol | input | 1 | Output polarity, 1 = active high |
| irq_mode | input | 1 | 0 = hysteresis, 1 = latched event |
| shutdown | input | 1 | Sleep request level |
| rd_strobe | input | 1 | Any register read this cycle |
| alarm_o | output | 1 | Polarity-adjusted alarm level |

## Verification
The bench targets a sample equal to a trip point. A design using a non-strict comparison would fire there. It also uses samples that differ from a trip point only in bits below the chosen resolution; an unmasked compare would trip on them. Runs are broken one conversion short of the target, which catches a counter that is never restarted or that triggers one early. In latched-event mode the bench checks that a second run above does nothing after a clear, and that shutdown clears the alarm in this mode but not in hysteresis mode. A design with a missing arm flip, or with a level-based shutdown clear, would show the wrong output there.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam int RUN_CNT_W = 3;
  localparam int RUN_MAX   = 6;

  typedef enum logic {ARM_LOW = 1'b0, ARM_HIGH = 1'b1} arm_e;

  function automatic logic [RUN_CNT_W-1:0] run_target(input logic [1:0] sel);
    case (sel)
      2'b00:   run_target = RUN_CNT_W'(1);
      2'b01:   run_target = RUN_CNT_W'(2);
      2'b10:   run_target = RUN_CNT_W'(4);
      default: run_target = RUN_CNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/thermo_limit_cmp.sv
module thermo_limit_cmp #(
  parameter int DATA_W  = 16,
  parameter int MIN_RES = 9,
  parameter int RES_W   = 2
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] trip_hi,
  input  logic [DATA_W-1:0] trip_lo,
  input  logic [RES_W-1:0]  res_sel,
  output logic              above,
  output logic              below
);
  logic [DATA_W-1:0] keep;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
      assign keep[i] = (32'(i) + 32'(MIN_RES) + 32'(res_sel)) >= 32'(DATA_W);
    end
  endgenerate

  logic signed [DATA_W-1:0] s_m, h_m, l_m;
  assign s_m = $signed(sample & keep);
  assign h_m = $signed(trip_hi & keep);
  assign l_m = $signed(trip_lo & keep);

  assign above = s_m > h_m;
  assign below = s_m < l_m;
endmodule

// File: rtl/thermo_run_ctr.sv
module thermo_run_ctr
  import thermo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 inc,
  input  logic [RUN_CNT_W-1:0] target,
  output logic                 hit,
  output logic [RUN_CNT_W-1:0] cnt_q
);
  logic [RUN_CNT_W:0] nxt;
  assign nxt = {1'b0, cnt_q} + 1'b1;
  assign hit = inc && (nxt >= {1'b0, target});

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (inc)    cnt_q <= hit ? target : nxt[RUN_CNT_W-1:0];
  end

  // R1: count bounded by the longest run
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= RUN_CNT_W'(RUN_MAX));

  // R4: a failed conversion restarts the run
  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/thermo_alarm_ctl.sv
module thermo_alarm_ctl
  import thermo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic conv_done,
  input  logic above,
  input  logic below,
  input  logic irq_mode,
  input  logic rd_strobe,
  input  logic shutdown,
  input  logic hit,
  output logic ctr_inc,
  output logic ctr_clr,
  output logic active_d,
  output logic active_q
);
  arm_e arm_q, arm_d;
  logic sd_q, sd_rise, clr_ev, cond, fail, deact;

  assign sd_rise = shutdown && !sd_q;
  assign clr_ev  = irq_mode && (rd_strobe || sd_rise);
  assign cond    = irq_mode ? ((arm_q == ARM_HIGH) ? above : below) : above;
  assign ctr_inc = !active_q && conv_done && cond;
  assign fail    = !active_q && conv_done && !cond;
  assign deact   = active_q && (irq_mode ? clr_ev : (conv_done && below));
  assign ctr_clr = fail || deact;

  always_comb begin
    active_d = active_q;
    arm_d    = arm_q;
    if (deact) begin
      active_d = 1'b0;
    end else if (ctr_inc && hit) begin
      active_d = 1'b1;
      if (irq_mode) arm_d = (arm_q == ARM_HIGH) ? ARM_LOW : ARM_HIGH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      arm_q    <= ARM_HIGH;
      sd_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      arm_q    <= arm_d;
      sd_q     <= shutdown;
    end
  end

  // R10: quiet cycles leave the alarm alone
  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!conv_done && !clr_ev) |=> $stable(active_q));

  // R5: a read clears a latched event
  p_read_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_mode && rd_strobe && active_q) |=> !active_q);

  // R4: one conversion below ends a hysteresis alarm
  p_hyst_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (!irq_mode && active_q && conv_done && below) |=> !active_q);

  // R7: shutdown edge does nothing in hysteresis mode
  p_sd_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (!irq_mode && active_q && !conv_done) |=> active_q);
endmodule

// File: rtl/thermo_trip_monitor.sv
module thermo_trip_monitor
  import thermo_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MIN_RES = 9,
  parameter int RES_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] trip_hi,
  input  logic [DATA_W-1:0] trip_lo,
  input  logic [RES_W-1:0]  res_sel,
  input  logic [1:0]        run_sel,
  input  logic              pol,
  input  logic              irq_mode,
  input  logic              shutdown,
  input  logic              rd_strobe,
  output logic              alarm_o
);
  logic rst_any;
  assign rst_any = rst || soft_rst;

  logic above, below, hit, ctr_inc, ctr_clr, active_d, active_q;
  logic [RUN_CNT_W-1:0] cnt_q;

  thermo_limit_cmp #(.DATA_W(DATA_W), .MIN_RES(MIN_RES), .RES_W(RES_W)) u_cmp (
    .sample(sample), .trip_hi(trip_hi), .trip_lo(trip_lo), .res_sel(res_sel),
    .above(above), .below(below)
  );

  thermo_run_ctr u_ctr (
    .clk(clk), .rst(rst_any), .clr(ctr_clr), .inc(ctr_inc),
    .target(run_target(run_sel)), .hit(hit), .cnt_q(cnt_q)
  );

  thermo_alarm_ctl u_ctl (
    .clk(clk), .rst(rst_any), .conv_done(conv_done), .above(above),
    .below(below), .irq_mode(irq_mode), .rd_strobe(rd_strobe),
    .shutdown(shutdown), .hit(hit), .ctr_inc(ctr_inc), .ctr_clr(ctr_clr),
    .active_d(active_d), .active_q(active_q)
  );

  logic pol_q;
  always_ff @(posedge clk) begin
    pol_q <= pol;
    if (rst_any) alarm_o <= 1'b1;
    else         alarm_o <= pol ? active_d : !active_d;
  end

  // R8: pin level matches state under the polarity in force
  p_pol_level_r8: assert property (@(posedge clk) disable iff (rst_any)
    1'b1 |=> alarm_o == (pol_q ? active_q : !active_q));

  // R9: reset leaves the pin at its idle level
  p_reset_idle_r9: assert property (@(posedge clk)
    rst_any |=> alarm_o);
endmodule

// File: tb/sim_thermo_trip_monitor.sv
module sim_thermo_trip_monitor;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, soft_rst, conv_done, pol, irq_mode, shutdown, rd_strobe;
  logic [15:0] sample, trip_hi, trip_lo;
  logic [1:0] res_sel, run_sel;
  logic alarm_o;

  thermo_trip_monitor u0 (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // independent model state
  bit m_act, m_armhi, m_sdq;
  int m_cnt;

  function automatic int tgt(input logic [1:0] s);
    case (s) 2'b00: return 1; 2'b01: return 2; 2'b10: return 4; default: return 6; endcase
  endfunction

  function automatic bit gt_m(input logic [15:0] a, input logic [15:0] b, input logic [1:0] r);
    logic [15:0] m = 16'hFFFF << (7 - r);
    return $signed(a & m) > $signed(b & m);
  endfunction

  task automatic model_step();
    bit ab, be, clr, cond;
    ab  = gt_m(sample, trip_hi, res_sel);
    be  = gt_m(trip_lo, sample, res_sel);
    clr = irq_mode && (rd_strobe || (shutdown && !m_sdq));
    if (rst || soft_rst) begin
      m_act = 0; m_cnt = 0; m_armhi = 1; m_sdq = 0;
      return;
    end
    if (m_act) begin
      if (irq_mode ? clr : (conv_done && be)) begin m_act = 0; m_cnt = 0; end
    end else if (conv_done) begin
      cond = irq_mode ? (m_armhi ? ab : be) : ab;
      if (cond) begin
        if (m_cnt + 1 >= tgt(run_sel)) begin
          m_act = 1; m_cnt = tgt(run_sel);
          if (irq_mode) m_armhi = !m_armhi;
        end else m_cnt++;
      end else m_cnt = 0;
    end
    m_sdq = shutdown;
  endtask

  task automatic check(input bit exp, input string tag);
    n_run++;
    if (alarm_o !== exp) begin
      n_fail++;
      $display("FAIL %s: alarm_o=%b expected %b at %0t", tag, alarm_o, exp, $time);
    end
  endtask

  // one clock with the current inputs; checks against the model
  task automatic step(input bit cv, input bit rd, input string tag);
    conv_done = cv; rd_strobe = rd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check((rst || soft_rst) ? 1'b1 : (pol ? m_act : !m_act), tag);
    conv_done = 0; rd_strobe = 0; soft_rst = 0;
  endtask

  task automatic conv(input logic [15:0] t, input string tag);
    sample = t; step(1, 0, tag);
  endtask

  // literal expectation of the active state
  task automatic expect_act(input bit act, input string tag);
    check(pol ? act : !act, tag);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1; soft_rst = 0; conv_done = 0; pol = 0; irq_mode = 0; shutdown = 0;
    rd_strobe = 0; sample = 0; trip_hi = 16'h0500; trip_lo = 16'h0480;
    res_sel = 2'b11; run_sel = 2'b01;
    @(negedge clk); step(0, 0, "R9 reset");
    rst = 0;
    step(0, 0, "R9 idle"); expect_act(0, "R9 idle after reset");

    // R1/R4: run of two in hysteresis mode, broken once
    conv(16'h0510, "R1 first above");     expect_act(0, "R1 one of two");
    conv(16'h04F0, "R4 break run");       expect_act(0, "R4 restart");
    conv(16'h0510, "R1 run 1");           expect_act(0, "R1 still one");
    conv(16'h0520, "R1 run 2");           expect_act(1, "R1 fires at two");
    conv(16'h04A0, "R4 between limits");  expect_act(1, "R4 holds in band");
    conv(16'h0480, "R3 equal low");       expect_act(1, "R3 equality no clear");
    shutdown = 1; step(0, 0, "R7 comp sd"); expect_act(1, "R7 comp shutdown ignored");
    shutdown = 0; step(0, 0, "R7 comp sd off");
    sample = 16'h0000; step(0, 0, "R10 no conv"); expect_act(1, "R10 no conv no change");
    conv(16'h0470, "R4 single below");    expect_act(0, "R4 single below clears");

    // R2/R3: masking at 9 bits
    run_sel = 2'b00; res_sel = 2'b00;
    conv(16'h0500, "R3 equal high");      expect_act(0, "R3 equality no trip");
    conv(16'h0570, "R2 sub-res above");   expect_act(0, "R2 masked bits ignored");
    res_sel = 2'b11;
    conv(16'h0570, "R2 12-bit above");    expect_act(1, "R2 visible at 12 bits");
    conv(16'h0400, "R4 clear");

    // R1: six-run
    run_sel = 2'b11;
    for (int i = 0; i < 5; i++) conv(16'h0600, "R1 six-run partial");
    expect_act(0, "R1 five of six");
    conv(16'h0600, "R1 six"); expect_act(1, "R1 six fires");
    conv(16'h0400, "R4 clear");

    // interrupt mode
    soft_rst = 1; step(0, 0, "R9 soft reset"); expect_act(0, "R9 soft reset idle");
    irq_mode = 1; run_sel = 2'b00;
    conv(16'h0600, "R5 trip");            expect_act(1, "R5 latched");
    conv(16'h0400, "R5 below ignored");   expect_act(1, "R5 latched through below");
    step(0, 1, "R5 read");                expect_act(0, "R5 read clears");
    conv(16'h0600, "R6 above after clear"); expect_act(0, "R6 armed low");
    conv(16'h0400, "R6 below");           expect_act(1, "R6 low event");
    shutdown = 1; step(0, 0, "R7 irq sd"); expect_act(0, "R7 shutdown clears");
    conv(16'h0600, "R6 high again");      expect_act(1, "R6 alternates back");
    step(0, 0, "R7 level held");          expect_act(1, "R7 level no repeat clear");
    shutdown = 0;
    sample = 16'h0600; step(1, 1, "R10 same cycle"); expect_act(0, "R10 clear wins");
    pol = 1; step(0, 0, "R8 pol high"); expect_act(0, "R8 inactive low");
    conv(16'h0400, "R8 event");           expect_act(1, "R8 active high");

    // constrained random
    for (int blk = 0; blk < 40; blk++) begin
      soft_rst = 1;
      irq_mode = $urandom_range(0, 1);
      pol = $urandom_range(0, 1);
      step(0, 0, "R9 random reset");
      for (int k = 0; k < 150; k++) begin
        int d;
        run_sel = (($urandom_range(0, 9) == 0) ? 2'($urandom) : run_sel);
        res_sel = (($urandom_range(0, 9) == 0) ? 2'($urandom) : res_sel);
        shutdown = ($urandom_range(0, 15) == 0) ? !shutdown : shutdown;
        d = $urandom_range(0, 160);
        sample = trip_hi + 16'(d) - 16'd80 - (($urandom_range(0, 1) != 0) ? 16'h0100 : 16'h0000);
        step($urandom_range(0, 2) != 0, $urandom_range(0, 11) == 0,
             irq_mode ? "R5 R6 random" : "R4 random");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial process::self().srandom(32'd1234);
endmodule